// File: doc/BRIEF.md
# Square Wave Tone Channel

This block is one programmable tone voice of a small sound unit. It turns four byte-wide control registers, written from a CPU-side write port, into a 4-bit sample stream. The tone is a square wave whose period is set by an 11-bit divider value F. Its high time is one of four duty fractions, and its amplitude is a linear 4-bit level. At a 4 MHz system clock the tone frequency is 125000 / (F + 1) Hz.

Playback is started by writing the length register. A length counter then counts down on a shared tick that a free-running 16-bit prescaler elsewhere in the chip supplies once every 65536 clocks. That prescaler is never aligned to the write, so the played duration carries up to one tick of uncertainty. A hold bit keeps the tone sounding regardless of the counter. The sample leaves the block unmixed; summing with other voices and the DAC sit outside it.

Top module: `sqw_tone_channel`

## Requirements
- R1: F = {per_hi[2:0], per_lo[7:0]}, with per_lo at wr_sel 0 and per_hi at wr_sel 1. Bits 7:3 of per_hi are ignored. The duty sequencer has 8 steps and advances one step every 4*(F+1) clocks, so one full tone period is 32*(F+1) clocks.
- R2: The duty code in ctrl bits 5:4 (ctrl at wr_sel 2) sets how many of the 8 steps are high: 00 gives 1 step, 01 gives 2, 10 gives 4 and 11 gives 6. The high steps come first, starting at step 0.
- R3: While the channel sounds, sample equals the volume in ctrl bits 3:0 during high steps and 0 during low steps. A volume of 0 gives a silent output.
- R4: A write to wr_sel 0 or wr_sel 1 restarts the sequencer at step 0 with a fresh step count. The sample in the cycle after that write is therefore the high level.
- R5: A write of value L to the length register (wr_sel 3) starts playback. With the hold bit clear, the channel keeps sounding through the next L+1 len_tick pulses and falls silent at pulse L+2. For L = 0 it falls silent at the second pulse.
- R6: With the hold bit (ctrl bit 6) set, the channel sounds continuously whether or not the length counter has expired. The counter keeps running, and clearing the hold bit before it expires leaves the tone playing until it expires.
- R7: After reset all registers are zero. Whenever the channel is not sounding (hold clear and no playback in progress), sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 0 period low, 1 period high, 2 control, 3 length |
| wr_data | input | 8 | Write data byte |
| len_tick | input | 1 | One-cycle pulse from the shared free-running length prescaler |
| sample | output | 4 | Current output level, 0 or the programmed volume |

## Verification
The assertions assume that len_tick is a single-cycle pulse and that wr_en carries at most one register write per cycle. They also assume that the period register only changes through a write, which always restarts the sequencer, so the step never moves by more than one position at a time. The bench keeps to these assumptions: it drives each tick and write for exactly one cycle on the falling edge. It measures duty and period over whole restarted periods, and it checks length expiry with a low divider, so any 32-cycle window covers one full period whatever its phase.

// File: rtl/sqw_pkg.sv
// Package: shared encodings for the square wave tone channel.
// Assumes an 8-step duty sequence; the step count per duty code is fixed here.
package sqw_pkg;

    localparam int STEPS  = 8;
    localparam int STEP_W = $clog2(STEPS);

    typedef enum logic [1:0] {
        SEL_PER_LO = 2'd0,
        SEL_PER_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_LEN    = 2'd3
    } reg_sel_e;

    // Number of high steps out of STEPS for a duty code.
    function automatic logic [STEP_W:0] duty_high_steps(input logic [1:0] code);
        case (code)
            2'd0:    return (STEP_W+1)'(1);
            2'd1:    return (STEP_W+1)'(2);
            2'd2:    return (STEP_W+1)'(4);
            default: return (STEP_W+1)'(6);
        endcase
    endfunction

endpackage

// File: rtl/sqw_regs.sv
// Module: sqw_regs
// Holds the period, control and length registers of the tone channel and
// produces the single-cycle restart and length-load strobes.
// Assumes PER_W is between 9 and 16 and that writes are one cycle wide.
module sqw_regs
    import sqw_pkg::*;
#(
    parameter int PER_W = 11,
    parameter int VOL_W = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    output logic [PER_W-1:0] period,
    output logic [VOL_W-1:0] vol,
    output logic [1:0]       duty,
    output logic             hold,
    output logic             restart,
    output logic             len_load,
    output logic [LEN_W-1:0] len_value
);
    localparam int HI_W = PER_W - 8;

    reg_sel_e         sel;
    logic [7:0]       per_lo;
    logic [HI_W-1:0]  per_hi;
    logic             unused_bits;

    assign sel         = reg_sel_e'(wr_sel);
    assign unused_bits = ^{wr_data[7:HI_W], wr_data[7]};

    // Register file update on CPU writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_lo <= '0;
            per_hi <= '0;
            vol    <= '0;
            duty   <= '0;
            hold   <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_PER_LO: per_lo <= wr_data;
                SEL_PER_HI: per_hi <= wr_data[HI_W-1:0];
                SEL_CTRL: begin
                    vol  <= wr_data[VOL_W-1:0];
                    duty <= wr_data[5:4];
                    hold <= wr_data[6];
                end
                default: ;
            endcase
        end
    end

    // Strobes and the assembled divider value.
    always_comb begin
        period    = {per_hi, per_lo};
        restart   = wr_en && (sel == SEL_PER_LO || sel == SEL_PER_HI);
        len_load  = wr_en && (sel == SEL_LEN);
        len_value = wr_data[LEN_W-1:0];
    end

endmodule

// File: rtl/sqw_duty_seq.sv
// Module: sqw_duty_seq
// Divides the clock by PRE*(period+1) and steps an 8-position duty sequence;
// flags the high steps for the selected duty code.
// Assumes the period only changes together with a restart pulse.
module sqw_duty_seq
    import sqw_pkg::*;
#(
    parameter int PER_W = 11,
    parameter int PRE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [PER_W-1:0]  period,
    input  logic [1:0]        duty,
    output logic [STEP_W-1:0] step,
    output logic              high
);
    localparam int DIV_W = PER_W + PRE_W;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    assign div_last = {period, {PRE_W{1'b1}}};

    // Clock divider and step counter, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_cnt <= '0;
            step    <= '0;
        end else if (div_cnt == div_last) begin
            div_cnt <= '0;
            step    <= step + STEP_W'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // High phase covers the first duty_high_steps positions.
    always_comb high = ({1'b0, step} < duty_high_steps(duty));

endmodule

// File: rtl/sqw_length.sv
// Module: sqw_length
// One-shot playback length counter decremented on an external tick.
// Assumes the tick is a one-cycle pulse from a free-running prescaler.
module sqw_length #(
    parameter int LEN_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LEN_W-1:0] load_val,
    input  logic           tick,
    output logic           active,
    output logic [LEN_W:0] left
);
    // Load L+1, count down per tick, stop at the tick that finds zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
        end else if (load) begin
            active <= 1'b1;
            left   <= {1'b0, load_val} + (LEN_W+1)'(1);
        end else if (tick && active) begin
            if (left == '0) active <= 1'b0;
            else            left   <= left - (LEN_W+1)'(1);
        end
    end

endmodule

// File: rtl/sqw_tone_channel.sv
// Module: sqw_tone_channel
// Square wave tone channel: register port, duty sequencer, length counter
// and output gating. Sample is combinational from registered state.
// Assumes len_tick comes from a shared free-running prescaler.
module sqw_tone_channel
    import sqw_pkg::*;
#(
    parameter int PER_W = 11,
    parameter int VOL_W = 4,
    parameter int LEN_W = 8,
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             len_tick,
    output logic [VOL_W-1:0] sample
);
    logic [PER_W-1:0]  period;
    logic [VOL_W-1:0]  ctrl_vol;
    logic [1:0]        ctrl_duty;
    logic              ctrl_hold;
    logic              restart;
    logic              len_load;
    logic [LEN_W-1:0]  len_value;
    logic [STEP_W-1:0] seq_step;
    logic              seq_high;
    logic              len_active;
    logic [LEN_W:0]    len_left;
    logic              sounding;

    sqw_regs #(.PER_W(PER_W), .VOL_W(VOL_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .period(period), .vol(ctrl_vol),
        .duty(ctrl_duty), .hold(ctrl_hold), .restart(restart),
        .len_load(len_load), .len_value(len_value)
    );

    sqw_duty_seq #(.PER_W(PER_W), .PRE_W(PRE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .period(period),
        .duty(ctrl_duty), .step(seq_step), .high(seq_high)
    );

    sqw_length #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .load(len_load), .load_val(len_value),
        .tick(len_tick), .active(len_active), .left(len_left)
    );

    // Gate the volume by the sounding state and the duty phase.
    always_comb begin
        sounding = len_active || ctrl_hold;
        sample   = (sounding && seq_high) ? ctrl_vol : '0;
    end

endmodule

// File: rtl/sqw_tone_checker.sv
// Module: sqw_tone_checker
// Property checks for sqw_tone_channel, attached by bind.
// Assumes single-cycle writes and ticks.
module sqw_tone_checker #(
    parameter int VOL_W  = 4,
    parameter int LEN_W  = 8,
    parameter int STEP_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [7:0]        wr_data,
    input logic              len_tick,
    input logic [VOL_W-1:0]  sample,
    input logic [VOL_W-1:0]  vol,
    input logic              hold,
    input logic [STEP_W-1:0] step,
    input logic              len_active,
    input logic [LEN_W:0]    len_left
);
    p_step_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step) |-> (step == STEP_W'($past(step) + 1'b1)) || (step == '0));

    p_high_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample != '0) |-> (step < STEP_W'(6)));

    p_sample_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample == '0) || (sample == vol));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel[1]) |=> (step == '0));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=>
            (len_active && len_left == {1'b0, $past(wr_data[LEN_W-1:0])} + 1'b1));

    p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (len_active && len_tick && len_left == '0 && !(wr_en && wr_sel == 2'd3))
            |=> !len_active);

    p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!len_active && !hold) |-> (sample == '0));

endmodule

bind sqw_tone_channel sqw_tone_checker #(
    .VOL_W(VOL_W), .LEN_W(LEN_W), .STEP_W(sqw_pkg::STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .len_tick(len_tick), .sample(sample),
    .vol(ctrl_vol), .hold(ctrl_hold), .step(seq_step),
    .len_active(len_active), .len_left(len_left)
);

// File: tb/sqw_tone_channel_bench.sv
// Bench for sqw_tone_channel: a vector table of period/duty/volume settings
// measured over whole periods, then directed reset, restart and length tests.
module sqw_tone_channel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       len_tick = 1'b0;
    logic [3:0] sample;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    sqw_tone_channel u_sqw_tone_channel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .len_tick(len_tick), .sample(sample)
    );

    always #5 clk = ~clk;

    // Vector table: period low/high bytes, control byte, expected F and high steps.
    localparam int NV = 6;
    localparam logic [7:0] V_LO   [NV] = '{8'h00, 8'h01, 8'h03, 8'h05, 8'h00, 8'hFF};
    localparam logic [7:0] V_HI   [NV] = '{8'h00, 8'h00, 8'hF8, 8'h00, 8'h01, 8'h07};
    localparam logic [7:0] V_CTRL [NV] = '{8'h4F, 8'h53, 8'h67, 8'h7A, 8'h69, 8'h41};
    localparam int         V_F    [NV] = '{0, 1, 3, 5, 256, 2047};
    localparam int         V_N    [NV] = '{1, 2, 4, 6, 4, 1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        len_tick = 1'b1;
        @(negedge clk);
        len_tick = 1'b0;
    endtask

    // Count cycles at level vol and cycles at any other nonzero value.
    task automatic window(input int n, input logic [3:0] vol,
                          output int hi_cnt, output int bad);
        hi_cnt = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            if (sample == vol && vol != 4'd0) hi_cnt++;
            else if (sample != 4'd0) bad++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    initial begin
        int hc, bad, per, first;
        // R7: reset state
        repeat (3) @(negedge clk);
        chk(sample == 4'd0, "R7 sample in reset", sample, 0);
        rst_n = 1'b1;
        window(40, 4'd0, hc, bad);
        chk(bad == 0, "R7 silent after reset", bad, 0);

        // Table walk: R1 period, R2 duty, R3 level
        for (int v = 0; v < NV; v++) begin
            wr(2'd2, V_CTRL[v]);
            wr(2'd1, V_HI[v]);
            wr(2'd0, V_LO[v]);
            per = 32 * (V_F[v] + 1);
            first = sample;
            window(per, V_CTRL[v][3:0], hc, bad);
            chk(first == V_CTRL[v][3:0], "R4 first step high", first, V_CTRL[v][3:0]);
            chk(hc == V_N[v] * 4 * (V_F[v] + 1), "R2 high cycles per period",
                hc, V_N[v] * 4 * (V_F[v] + 1));
            chk(bad == 0, "R3 only 0 or volume", bad, 0);
            chk(sample == V_CTRL[v][3:0], "R1 next period starts high",
                sample, V_CTRL[v][3:0]);
        end

        // R3: volume zero is silent
        wr(2'd2, 8'h60);
        wr(2'd0, 8'h00);
        window(32, 4'd0, hc, bad);
        chk(bad == 0, "R3 volume 0 silent", bad, 0);

        // R4: period-high write restarts mid-period
        wr(2'd2, 8'h45);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        repeat (20) @(negedge clk);
        chk(sample == 4'd0, "R4 low phase before restart", sample, 0);
        wr(2'd1, 8'h00);
        first = sample;
        window(64, 4'd5, hc, bad);
        chk(first == 5, "R4 restart returns to high", first, 5);
        chk(hc == 8, "R4 full high phase after restart", hc, 8);

        // R5: one-shot length, L = 2
        wr(2'd2, 8'h25);
        wr(2'd0, 8'h00);
        window(32, 4'd5, hc, bad);
        chk(hc == 0 && bad == 0, "R7 idle without playback", hc, 0);
        wr(2'd3, 8'd2);
        for (int t = 0; t < 3; t++) begin
            tick();
            window(32, 4'd5, hc, bad);
            chk(hc == 16, "R5 sounding through L+1 ticks", hc, 16);
        end
        tick();
        window(32, 4'd5, hc, bad);
        chk(hc == 0 && bad == 0, "R5 silent at tick L+2", hc, 0);

        // R5: L = 0 edge
        wr(2'd3, 8'd0);
        tick();
        window(32, 4'd5, hc, bad);
        chk(hc == 16, "R5 L=0 sounding after first tick", hc, 16);
        tick();
        window(32, 4'd5, hc, bad);
        chk(hc == 0, "R5 L=0 silent at second tick", hc, 0);

        // R6: hold keeps sounding past expiry, clearing it silences
        wr(2'd2, 8'h65);
        wr(2'd3, 8'd1);
        repeat (3) tick();
        window(32, 4'd5, hc, bad);
        chk(hc == 16, "R6 hold sounds after expiry", hc, 16);
        wr(2'd2, 8'h25);
        window(32, 4'd5, hc, bad);
        chk(hc == 0, "R6 clear hold after expiry silences", hc, 0);

        // R6: clearing hold before expiry leaves playback running
        wr(2'd2, 8'h65);
        wr(2'd3, 8'd1);
        tick();
        wr(2'd2, 8'h25);
        window(32, 4'd5, hc, bad);
        chk(hc == 16, "R6 counter still running after hold clear", hc, 16);
        repeat (2) tick();
        window(32, 4'd5, hc, bad);
        chk(hc == 0, "R6 expiry after hold cleared", hc, 0);

        // R7: reset while sounding clears the registers
        wr(2'd2, 8'h4F);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sample == 4'd0, "R7 reset silences", sample, 0);
        rst_n = 1'b1;
        window(40, 4'd15, hc, bad);
        chk(hc == 0 && bad == 0, "R7 registers cleared by reset", hc, 0);

        finish_run();
    end

endmodule